// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a watchdog that counts timebase ticks and expires every power-of-two number of ticks, with the interval picked by a two-bit selector. Each expiry moves the watchdog one step along an escalation path, and a two-bit status register records the step. The first unserviced expiry arms the watchdog. The next one sets an interrupt status bit, which drives the interrupt line when interrupts are enabled. A further expiry asks for a system reset.

Software keeps the system alive by writing ones to the status bits to clear them. The tick counter restarts after every expiry and keeps running between expiries. The timebase that produces `tbTick` and the logic that acts on `rstReq` are outside this block.

Top module: `watchdog_two_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `status` reads 2'b00 and `wdIrq` and `rstReq` are 0. The tick count also restarts from zero.
- R2: The interval is 2^(PER_BASE_LOG + PER_STEP_LOG*perSel) ticks. The defaults give 2^17, 2^21, 2^25 and 2^29 for `perSel` = 0, 1, 2 and 3. An expiry happens on the edge that samples the last tick of the interval.
- R3: On an expiry where the effective status is 2'b00 or 2'b01, `status[1]` (the arm bit) is set.
- R4: On an expiry where the effective status is 2'b10, `status[0]` (the interrupt status bit) is set.
- R5: `wdIrq` is high exactly while `status[0]` is 1 and `irqEn` is 1.
- R6: On an expiry where the effective status is 2'b11, `rstReq` is high for exactly the one cycle after that edge, and `status` stays 2'b11.
- R7: A cycle with `stsWrEn` high clears each status bit whose `stsWrData` bit is 1 (bit 1 for the arm bit, bit 0 for the interrupt bit). Zeros leave the bit as it is. Clearing the interrupt bit drops `wdIrq`.
- R8: A clear and an expiry in the same cycle act in order: the clear first, then the escalation step on the cleared value.
- R9: The count moves only on cycles where `tbTick` is high, and it restarts from zero after every expiry. Cycles without a tick change nothing.
- R10: If `perSel` is lowered while the count already meets or passes the new interval, the next tick expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbTick | input | 1 | One-cycle timebase tick |
| perSel | input | 2 | Interval selector |
| irqEn | input | 1 | Interrupt enable |
| stsWrEn | input | 1 | Status write-one-to-clear strobe |
| stsWrData | input | 2 | Clear mask: [1] arm bit, [0] interrupt bit |
| status | output | 2 | [1] arm bit, [0] interrupt status bit |
| wdIrq | output | 1 | Watchdog interrupt (level) |
| rstReq | output | 1 | One-cycle reset request |

## Verification
The bench sweeps every interval with small parameters and counts ticks up to one short of the interval, then one more. An off-by-one counter would expire a tick early or a tick late. It walks the full escalation path under each selector. A design that skipped a stage or cleared the status on a reset request would show the wrong status bits or a wide `rstReq`. The bench also places a clear in the very cycle of an expiry, which catches designs that escalate from the value before the clear. It also drops the selector below a count that is already running, which catches a design that waits for the counter to wrap.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Status encoding: [1] arm bit, [0] interrupt status bit
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_IRQ_ONLY = 2'b01,
    ST_ARMED    = 2'b10,
    ST_FULL     = 2'b11
  } wdt_stage_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setArm;
    logic setIrq;
    logic clrArm;
    logic clrIrq;
    logic fireRst;
  } wdt_strobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath #(
  parameter int PER_BASE_LOG = 17,
  parameter int PER_STEP_LOG = 4,
  parameter int SEL_W        = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbTick,
  input  logic [SEL_W-1:0]    perSel,
  input  wdt_pkg::wdt_strobe_t strobe,
  output logic                expire,
  output logic [1:0]          stsQ,
  output logic                rstReqQ
);
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int MAX_LOG = PER_BASE_LOG + PER_STEP_LOG * (NUM_SEL - 1);

  logic [MAX_LOG-1:0] limitTab [NUM_SEL];
  logic [MAX_LOG-1:0] tickCnt;
  logic [MAX_LOG-1:0] curLimit;

  // Last count value of each interval: 2^log - 1
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_limit
    localparam int LOGV = PER_BASE_LOG + PER_STEP_LOG * g;
    assign limitTab[g] = {MAX_LOG{1'b1}} >> (MAX_LOG - LOGV);
  end

  assign curLimit = limitTab[perSel];
  assign expire   = tbTick && (tickCnt >= curLimit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
    end else if (expire) begin
      tickCnt <= '0;
    end else if (tbTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stsQ    <= 2'b00;
      rstReqQ <= 1'b0;
    end else begin
      stsQ    <= (stsQ & ~{strobe.clrArm, strobe.clrIrq})
               | {strobe.setArm, strobe.setIrq};
      rstReqQ <= strobe.fireRst;
    end
  end
endmodule

// File: rtl/wdt_control.sv
module wdt_control (
  input  logic                 expire,
  input  logic [1:0]           stsQ,
  input  logic                 stsWrEn,
  input  logic [1:0]           stsWrData,
  output wdt_pkg::wdt_strobe_t strobe
);
  import wdt_pkg::*;

  logic [1:0] effSts;

  always_comb begin
    strobe        = '0;
    strobe.clrArm = stsWrEn && stsWrData[1];
    strobe.clrIrq = stsWrEn && stsWrData[0];
    effSts        = stsQ & ~{strobe.clrArm, strobe.clrIrq};
    if (expire) begin
      unique case (wdt_stage_e'(effSts))
        ST_IDLE, ST_IRQ_ONLY: strobe.setArm  = 1'b1;
        ST_ARMED:             strobe.setIrq  = 1'b1;
        ST_FULL:              strobe.fireRst = 1'b1;
        default:              strobe.setArm  = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/watchdog_two_stage.sv
module watchdog_two_stage #(
  parameter int PER_BASE_LOG = 17,
  parameter int PER_STEP_LOG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbTick,
  input  logic [1:0] perSel,
  input  logic       irqEn,
  input  logic       stsWrEn,
  input  logic [1:0] stsWrData,
  output logic [1:0] status,
  output logic       wdIrq,
  output logic       rstReq
);
  wdt_pkg::wdt_strobe_t strobe;
  logic                 expire;
  logic [1:0]           stsQ;

  wdt_datapath #(
    .PER_BASE_LOG(PER_BASE_LOG),
    .PER_STEP_LOG(PER_STEP_LOG),
    .SEL_W       (2)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tbTick (tbTick),
    .perSel (perSel),
    .strobe (strobe),
    .expire (expire),
    .stsQ   (stsQ),
    .rstReqQ(rstReq)
  );

  wdt_control u_ctl (
    .expire   (expire),
    .stsQ     (stsQ),
    .stsWrEn  (stsWrEn),
    .stsWrData(stsWrData),
    .strobe   (strobe)
  );

  assign status = stsQ;
  assign wdIrq  = stsQ[0] && irqEn;
endmodule

// File: rtl/watchdog_two_stage_chk.sv
module watchdog_two_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tbTick,
  input logic       irqEn,
  input logic       stsWrEn,
  input logic [1:0] stsWrData,
  input logic [1:0] status,
  input logic       wdIrq,
  input logic       rstReq
);
  // R5: the interrupt needs the status bit
  p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdIrq |-> status[0]);
  // R5: no interrupt while disabled
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEn |-> !wdIrq);
  // R6: the reset request lasts one cycle
  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |=> !rstReq);
  // R6: the reset request comes only from the full stage
  p_rst_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |-> status == 2'b11);
  // R3/R9: the arm bit is only set on a tick
  p_arm_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(tbTick));
  // R4: the interrupt bit rises only after arming
  p_irq_after_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> ($past(status[1]) && $past(tbTick)));
  // R7: write-one-to-clear with no tick
  p_clear_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stsWrEn && stsWrData[1] && !tbTick) |=> !status[1]);
  p_clear_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stsWrEn && stsWrData[0] && !tbTick) |=> !status[0]);
endmodule

bind watchdog_two_stage watchdog_two_stage_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tbTick   (tbTick),
  .irqEn    (irqEn),
  .stsWrEn  (stsWrEn),
  .stsWrData(stsWrData),
  .status   (status),
  .wdIrq    (wdIrq),
  .rstReq   (rstReq)
);

// File: tb/test_watchdog_two_stage.sv
`timescale 1ns/1ps
module test_watchdog_two_stage;
  localparam int BASE = 2;
  localparam int STEP = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbTick = 1'b0;
  logic [1:0] perSel = 2'd0;
  logic       irqEn = 1'b0;
  logic       stsWrEn = 1'b0;
  logic [1:0] stsWrData = 2'b00;
  logic [1:0] status;
  logic       wdIrq;
  logic       rstReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  watchdog_two_stage #(.PER_BASE_LOG(BASE), .PER_STEP_LOG(STEP)) i_watchdog_two_stage (
    .clk(clk), .rst_n(rst_n), .tbTick(tbTick), .perSel(perSel), .irqEn(irqEn),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .status(status), .wdIrq(wdIrq),
    .rstReq(rstReq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; tbTick = 1'b0; stsWrEn = 1'b0; stsWrData = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One tick, then sit in the cycle after the sampling edge
  task automatic tick1();
    @(negedge clk) tbTick = 1'b1;
    @(negedge clk) tbTick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic w1c(input logic [1:0] d);
    @(negedge clk) begin stsWrEn = 1'b1; stsWrData = d; end
    @(negedge clk) begin stsWrEn = 1'b0; stsWrData = 2'b00; end
  endtask

  initial begin
    #2_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R1 reset state, during and after reset
    repeat (2) @(negedge clk);
    check("R1 status in reset", status, 0);
    check("R1 rstReq in reset", rstReq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status, 0);
    check("R1 wdIrq after reset", wdIrq, 0);

    // R2/R3/R4/R5/R6 sweep over every selector
    for (int sel = 0; sel < 4; sel++) begin
      automatic int per = 1 << (BASE + STEP * sel);
      perSel = sel[1:0];
      irqEn  = 1'b1;
      doReset();
      ticks(per - 1);
      check("R2 no early expiry", status, 0);
      tick1();
      check("R3 arm on first expiry", status, 2);
      ticks(per - 1);
      check("R2 armed holds", status, 2);
      tick1();
      check("R4 irq bit on second expiry", status, 3);
      check("R5 irq raised", wdIrq, 1);
      ticks(per - 1);
      check("R6 no early reset request", rstReq, 0);
      tick1();
      check("R6 reset request high", rstReq, 1);
      check("R6 status stays full", status, 3);
      @(negedge clk);
      check("R6 reset request one cycle", rstReq, 0);
    end

    // R5 gating by irqEn
    irqEn = 1'b0;
    @(negedge clk);
    check("R5 irq gated off", wdIrq, 0);
    irqEn = 1'b1;
    @(negedge clk);
    check("R5 irq ungated", wdIrq, 1);

    // R7 write-one-to-clear
    w1c(2'b00);
    check("R7 zero write no effect", status, 3);
    w1c(2'b01);
    check("R7 clear irq bit", status, 2);
    check("R7 irq drops", wdIrq, 0);
    w1c(2'b10);
    check("R7 clear arm bit", status, 0);

    // R3 from 01: expiry sets arm bit
    perSel = 2'd0;
    doReset();
    ticks(8);
    check("R3 setup full", status, 3);
    w1c(2'b10);
    check("R7 clear arm leaves irq", status, 1);
    tick1();  // count was restarted by expiry, 3 more needed
    ticks(3);
    check("R3 expiry from 01 sets arm", status, 3);

    // R8 clear and expiry in the same cycle
    doReset();
    ticks(4);
    check("R8 setup armed", status, 2);
    ticks(3);
    @(negedge clk) begin tbTick = 1'b1; stsWrEn = 1'b1; stsWrData = 2'b10; end
    @(negedge clk) begin tbTick = 1'b0; stsWrEn = 1'b0; stsWrData = 2'b00; end
    check("R8 clear then escalate", status, 2);
    check("R8 no irq", wdIrq, 0);

    // R9 idle cycles do nothing, count restarts after expiry
    doReset();
    ticks(3);
    repeat (20) @(negedge clk);
    check("R9 idle no expiry", status, 0);
    tick1();
    check("R9 expiry after ticks only", status, 2);
    ticks(3);
    check("R9 count restarted", status, 2);

    // R10 lowering the selector below a running count
    perSel = 2'd3;
    doReset();
    ticks(10);
    check("R10 no expiry at 10 of 32", status, 0);
    perSel = 2'd0;
    tick1();
    check("R10 immediate expiry", status, 2);

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule